// File: doc/BRIEF.md
# Supply Rail Comparator Qualifier

This block cleans up the digital outputs of the voltage comparators that watch a set of supply rails. Every rail has two comparators. The first reports that the rail sits below its upper limit, and the second reports that it sits above its lower limit. Each of these channels can pass through its own rejection filter. The filter accepts a new level only once that level has held for a fixed time, measured in ticks of a slow timing strobe. A channel that watches a clean supply can skip its filter and follow its input one clock later.

For each rail, a window mode can combine the two filtered bits into a single in-range flag for the sequencing logic. The individual filtered bits stay visible whether or not the window mode is on. The rejection time and the tick rate are parameters, and the tick count the filter needs is derived from them. With the defaults (250 kHz tick, 64 µs rejection) the filter needs 16 ticks.

Top module: `rail_qualifier`

## Requirements
- R1: While reset is asserted, and after its release until a level is accepted, every filtered output and every in-range flag is 0, whatever the comparator inputs are.
- R2: With its filter enabled, a channel adopts an input level that differs from its held output on the clock edge where the 16th tick (default parameters) is sampled during which the input has continuously differed.
- R3: With its filter enabled, an input that returns to the held level before that tick clears the count. A pulse shorter than the rejection time never reaches the output, and a later change again needs the full 16 ticks.
- R4: With its filter enabled, a channel's output changes only on a clock edge where the tick strobe is sampled high.
- R5: With its filter disabled, a channel's output equals its input as sampled on the previous clock edge, regardless of the tick strobe.
- R6: Filter-enable bit 2r selects the filter of rail r's below-upper-limit channel, and bit 2r+1 selects the filter of its above-lower-limit channel. Each bit affects only its own channel.
- R7: With window mode on for rail r, its in-range flag is 1 exactly when both of that rail's filtered bits are 1, in the same cycle as those bits.
- R8: With window mode off for rail r, its in-range flag is 0 and the rail's two filtered bits are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Timing strobe, one clock wide per tick |
| below_max_raw_i | input | NUM_RAILS | Sampled comparator bits, 1 = rail below its upper limit |
| above_min_raw_i | input | NUM_RAILS | Sampled comparator bits, 1 = rail above its lower limit |
| filt_en_i | input | 2*NUM_RAILS | Per-channel filter enable, bit 2r upper / 2r+1 lower of rail r |
| win_en_i | input | NUM_RAILS | Per-rail window mode enable |
| below_max_o | output | NUM_RAILS | Filtered below-upper-limit bits |
| above_min_o | output | NUM_RAILS | Filtered above-lower-limit bits |
| in_win_o | output | NUM_RAILS | Per-rail in-range flags |

## Verification
The bench builds the block with its default parameters: five rails, a 250 kHz tick and a 64 µs rejection time, which give a 16-tick threshold. The bench pulses the tick every fourth clock, so a full rejection window takes 64 clocks. That makes the exact tick at which a level is adopted, the 15-tick near miss, and a pulse cut short after 10 ticks all cheap to reach. Mixing enabled and bypassed channels on the same rail exercises the channel-to-enable-bit mapping and the window merge.

// File: rtl/rq_pkg.sv
package rq_pkg;

  // Ticks needed to span the rejection time, rounded up, never below one.
  function automatic int unsigned hold_ticks(int unsigned tick_khz, int unsigned reject_us);
    int unsigned t;
    t = (tick_khz * reject_us + 999) / 1000;
    return (t < 1) ? 1 : t;
  endfunction

endpackage

// File: rtl/rq_rst_sync.sv
module rq_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/rq_deglitch.sv
module rq_deglitch #(
  parameter int unsigned HOLD_TICKS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic filt_en_i,
  input  logic raw_i,
  output logic q_o
);
  localparam int unsigned CW = (HOLD_TICKS < 2) ? 1 : $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

  logic          held_q, held_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          differ;
  logic          upd_en;

  assign differ = (raw_i != held_q);

  // Next-state logic
  always_comb begin
    held_d = held_q;
    cnt_d  = cnt_q;
    if (!filt_en_i) begin
      held_d = raw_i;
      cnt_d  = '0;
    end else if (!differ) begin
      cnt_d  = '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        held_d = raw_i;
        cnt_d  = '0;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  assign upd_en = (held_d != held_q) || (cnt_d != cnt_q);

  // State registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      held_q <= held_d;
      cnt_q  <= cnt_d;
    end
  end

  assign q_o = held_q;
endmodule

// File: rtl/rq_window.sv
module rq_window (
  input  logic below_max_i,
  input  logic above_min_i,
  input  logic win_en_i,
  output logic in_win_o
);
  always_comb begin
    in_win_o = 1'b0;
    if (win_en_i) in_win_o = below_max_i & above_min_i;
  end
endmodule

// File: rtl/rail_qualifier.sv
module rail_qualifier #(
  parameter int unsigned NUM_RAILS = 5,
  parameter int unsigned TICK_KHZ  = 250,
  parameter int unsigned REJECT_US = 64
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic [NUM_RAILS-1:0]   below_max_raw_i,
  input  logic [NUM_RAILS-1:0]   above_min_raw_i,
  input  logic [2*NUM_RAILS-1:0] filt_en_i,
  input  logic [NUM_RAILS-1:0]   win_en_i,
  output logic [NUM_RAILS-1:0]   below_max_o,
  output logic [NUM_RAILS-1:0]   above_min_o,
  output logic [NUM_RAILS-1:0]   in_win_o
);
  import rq_pkg::*;

  localparam int unsigned NUM_CH     = 2 * NUM_RAILS;
  localparam int unsigned HOLD_TICKS = hold_ticks(TICK_KHZ, REJECT_US);

  logic              rst_n_q;
  logic [NUM_CH-1:0] chan_raw;
  logic [NUM_CH-1:0] chan_q;

  rq_rst_sync i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_q)
  );

  // Channel 2r = below-upper-limit, 2r+1 = above-lower-limit of rail r
  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    assign chan_raw[2*r]   = below_max_raw_i[r];
    assign chan_raw[2*r+1] = above_min_raw_i[r];
    assign below_max_o[r]  = chan_q[2*r];
    assign above_min_o[r]  = chan_q[2*r+1];

    rq_window i_window (
      .below_max_i (chan_q[2*r]),
      .above_min_i (chan_q[2*r+1]),
      .win_en_i    (win_en_i[r]),
      .in_win_o    (in_win_o[r])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    rq_deglitch #(
      .HOLD_TICKS (HOLD_TICKS)
    ) i_deglitch (
      .clk_i     (clk_i),
      .rst_ni    (rst_n_q),
      .tick_i    (tick_i),
      .filt_en_i (filt_en_i[c]),
      .raw_i     (chan_raw[c]),
      .q_o       (chan_q[c])
    );
  end
endmodule

// File: rtl/rq_checker.sv
module rq_checker #(
  parameter int unsigned NUM_RAILS = 5
) (
  input logic                   clk_i,
  input logic                   rst_n,
  input logic                   tick_i,
  input logic [2*NUM_RAILS-1:0] filt_en_i,
  input logic [2*NUM_RAILS-1:0] chan_raw,
  input logic [2*NUM_RAILS-1:0] chan_q,
  input logic [NUM_RAILS-1:0]   win_en_i,
  input logic [NUM_RAILS-1:0]   in_win_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    $rose(rst_n) |-> (chan_q == '0) && (in_win_o == '0));

  for (genvar c = 0; c < 2*NUM_RAILS; c++) begin : g_ch
    // R4
    stable_off_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      $past(rst_n) && $past(filt_en_i[c]) && !$past(tick_i) |-> $stable(chan_q[c]));
    // R5
    bypass_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      $past(rst_n) && !$past(filt_en_i[c]) |-> chan_q[c] == $past(chan_raw[c]));
    // R2
    adopt_input_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      $past(rst_n) && (chan_q[c] != $past(chan_q[c])) |-> chan_q[c] == $past(chan_raw[c]));
  end

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rl
    // R7
    win_track_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      $stable(win_en_i[r]) && $stable(chan_q[2*r]) && $stable(chan_q[2*r+1])
        |-> $stable(in_win_o[r]));
    // R8
    win_off_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
      $fell(win_en_i[r]) |-> !in_win_o[r]);
  end
endmodule

bind rail_qualifier rq_checker #(.NUM_RAILS(NUM_RAILS)) i_rq_checker (
  .clk_i     (clk_i),
  .rst_n     (rst_n_q),
  .tick_i    (tick_i),
  .filt_en_i (filt_en_i),
  .chan_raw  (chan_raw),
  .chan_q    (chan_q),
  .win_en_i  (win_en_i),
  .in_win_o  (in_win_o)
);

// File: tb/test_rail_qualifier.sv
`timescale 1ns/1ps
module test_rail_qualifier;
  localparam int N = 5;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         tick_i;
  logic [N-1:0] below_max_raw_i, above_min_raw_i, win_en_i;
  logic [2*N-1:0] filt_en_i;
  logic [N-1:0] below_max_o, above_min_o, in_win_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  rail_qualifier i_rail_qualifier (
    .clk_i, .rst_ni, .tick_i, .below_max_raw_i, .above_min_raw_i,
    .filt_en_i, .win_en_i, .below_max_o, .above_min_o, .in_win_o
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One clock: apply tick value, advance to the next falling edge
  task automatic step(logic t);
    tick_i = t;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      step(1'b1);
      step(1'b0); step(1'b0); step(1'b0);
    end
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; tick_i = 1'b0;
    below_max_raw_i = '1; above_min_raw_i = '1;
    filt_en_i = '1; win_en_i = '1;
    for (int i = 0; i < 4; i++) step(1'b1);
    chk("R1 below_max in reset", below_max_o, 0);
    chk("R1 above_min in reset", above_min_o, 0);
    chk("R1 in_win in reset", in_win_o, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) step(1'b0);
    chk("R1 below_max after release", below_max_o, 0);
    chk("R1 in_win after release", in_win_o, 0);
  endtask

  task automatic t_adopt;
    ticks(15);
    chk("R2 no adopt at 15 ticks", below_max_o, 0);
    chk("R2 no adopt at 15 ticks lower", above_min_o, 0);
    step(1'b0); step(1'b0); step(1'b0);
    chk("R4 no change without tick", below_max_o, 0);
    step(1'b1);
    chk("R2 adopt at 16th tick", below_max_o, 5'h1f);
    chk("R2 adopt at 16th tick lower", above_min_o, 5'h1f);
    chk("R7 all rails in window", in_win_o, 5'h1f);
  endtask

  task automatic t_reject;
    below_max_raw_i[0] = 1'b0;
    ticks(10);
    below_max_raw_i[0] = 1'b1;
    step(1'b0);
    chk("R3 short pulse rejected", below_max_o[0], 1);
    below_max_raw_i[0] = 1'b0;
    ticks(15);
    chk("R3 count restarted", below_max_o[0], 1);
    step(1'b1);
    chk("R3 full window after restart", below_max_o[0], 0);
    chk("R7 rail0 out of window", in_win_o, 5'h1e);
  endtask

  task automatic t_bypass;
    filt_en_i = 10'b00_0000_0001;
    below_max_raw_i[0] = 1'b1;
    above_min_raw_i[0] = 1'b0;
    step(1'b0);
    chk("R5 bypass follows in one clock", above_min_o[0], 0);
    chk("R6 filtered channel held", below_max_o[0], 0);
    chk("R6 other rails untouched", below_max_o[4:1], 4'hf);
    above_min_raw_i[3] = 1'b0;
    step(1'b0);
    chk("R5 bypass rail3 lower", above_min_o, 5'h16);
    ticks(15);
    step(1'b1);
    chk("R6 filtered channel adopts", below_max_o[0], 1);
  endtask

  task automatic t_window;
    filt_en_i = '0;
    below_max_raw_i = '1; above_min_raw_i = '1; win_en_i = '1;
    step(1'b0);
    chk("R7 all in window", in_win_o, 5'h1f);
    above_min_raw_i[2] = 1'b0;
    step(1'b0);
    chk("R7 lower fail rail2", in_win_o, 5'h1b);
    above_min_raw_i[2] = 1'b1; below_max_raw_i[2] = 1'b0;
    step(1'b0);
    chk("R7 upper fail rail2", in_win_o, 5'h1b);
    below_max_raw_i[2] = 1'b1; win_en_i[2] = 1'b0;
    step(1'b0);
    chk("R8 window off forces 0", in_win_o, 5'h1b);
    chk("R8 bits unaffected upper", below_max_o, 5'h1f);
    chk("R8 bits unaffected lower", above_min_o, 5'h1f);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    tick_i = 1'b0;
    @(negedge clk_i);
    t_reset();
    t_adopt();
    t_reject();
    t_bypass();
    t_window();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule